// File: doc/BRIEF.md
# Degraded Mode Selection Controller

This block keeps the operating mode of a system whose three monitored tasks are each watched by an external execution-time monitor. The three tasks are a high-rate sequencer, a low-rate estimator and an event-driven receiver. The monitor reports each timing-bound violation as a task code together with the kind of bound that was broken (lower or upper). The controller keeps a record of the tasks that have violated their bounds. From that record it decodes one of six modes, ordered from fully nominal to survival. It drives the mode code to software, a quarantine mask and a timer-set selector to the monitor.

Violations only add tasks to the record, so the mode can only move toward the all-violated state. A separate restoration input, raised when a quarantined task is seen to behave nominally again, removes that task from the record. Only when the record is empty does the mode return to nominal. Each change of the record is announced by a one-cycle synchronise pulse. The new mode, mask and timer set appear in the cycle that follows. A static configuration input selects whether an estimator-only fault uses the position-fix-ignoring mode or the raw-data bypass mode.

Top module: `degrade_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is 0 (nominal), `quar_o` is 0, `timer_set_o` is 0 and `sync_o` is 0.
- R2: With only the sequencer (task code 0) in the record, the mode is C (code 3).
- R3: With only the receiver (task code 2), or with the estimator and the receiver together, the mode is A (code 1). With only the estimator (task code 1), the mode is A when `alt_b_i` is 0 and B (code 2) when it is 1.
- R4: With the sequencer and exactly one of the other two tasks in the record, the mode is D (code 4).
- R5: With all three tasks in the record, the mode is survival (code 5).
- R6: A violation only ever sets record bits. A repeat violation by a task already in the record has no effect, and neither does task code 3. Neither one produces a pulse or a change at the outputs.
- R7: `quar_o` shows the record: bit 0 is the sequencer, bit 1 the estimator and bit 2 the receiver.
- R8: `timer_set_o` is {mode code, bound}. The bound bit is the one carried by the most recent violation that set a new record bit, with 1 meaning upper (worst-case) and 0 meaning lower (best-case).
- R9: A restoration event clears the bit of that task, and the mode is decoded again from what remains. The mode is nominal only when the record is empty. A restoration event for a task that is not quarantined has no effect.
- R10: A record change raises `sync_o` for exactly one cycle, two clock edges after the event is sampled. `mode_o`, `quar_o` and `timer_set_o` take their new values at the next edge, and they never change except right after a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| viol_valid_i | input | 1 | Violation report valid |
| viol_tid_i | input | TID_W | Task code of the violating task (0 sequencer, 1 estimator, 2 receiver) |
| viol_upper_i | input | 1 | Bound broken: 1 upper, 0 lower |
| restore_valid_i | input | 1 | Restoration report valid |
| restore_tid_i | input | TID_W | Task code of the restored task |
| alt_b_i | input | 1 | Static: estimator-only fault uses raw-data bypass mode |
| mode_o | output | 3 | Applied mode code |
| quar_o | output | 3 | Quarantine mask, one bit per task |
| timer_set_o | output | 4 | Monitor timer set: {mode, bound} |
| sync_o | output | 1 | One-cycle synchronise pulse ahead of an update |

## Verification
A corrupted violation record shows up at the ports as a wrong mode code and a wrong quarantine mask, three edges after the event that caused it. A lost or spurious record bit also appears as a missing or extra synchronise pulse two edges after the event. The directed cases compare `mode_o`, `quar_o`, `timer_set_o` and the pulse timing in those exact cycles. They cover each reachable combination of faults, both settings of the configuration input, the ignored events, and the restoration path back to nominal.

// File: rtl/degrade_mode_pkg.sv
package degrade_mode_pkg;
  localparam int NTASK  = 3;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NOM  = 3'd0,
    MODE_A    = 3'd1,
    MODE_B    = 3'd2,
    MODE_C    = 3'd3,
    MODE_D    = 3'd4,
    MODE_SURV = 3'd5
  } mode_e;

  // record bit positions
  localparam int BIT_SEQ = 0;
  localparam int BIT_EST = 1;
  localparam int BIT_RCV = 2;
endpackage

// File: rtl/dm_record.sv
module dm_record
  import degrade_mode_pkg::*;
#(
  parameter int TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             viol_valid_i,
  input  logic [TID_W-1:0] viol_tid_i,
  input  logic             viol_upper_i,
  input  logic             rest_valid_i,
  input  logic [TID_W-1:0] rest_tid_i,
  output logic [NTASK-1:0] rec_o,
  output logic             upper_o
);
  logic [NTASK-1:0] vmask, rmask, rec_q, rec_d;
  logic             upper_q, upper_d;

  for (genvar g = 0; g < NTASK; g++) begin : g_mask
    assign vmask[g] = viol_valid_i && (viol_tid_i == TID_W'(g));
    assign rmask[g] = rest_valid_i && (rest_tid_i == TID_W'(g));
  end

  always_comb begin
    // violation wins over a same-cycle restore of the same task
    rec_d   = (rec_q & ~rmask) | vmask;
    upper_d = |(vmask & ~rec_q) ? viol_upper_i : upper_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q   <= '0;
      upper_q <= 1'b0;
    end else begin
      rec_q   <= rec_d;
      upper_q <= upper_d;
    end
  end

  assign rec_o   = rec_q;
  assign upper_o = upper_q;
endmodule

// File: rtl/dm_decode.sv
module dm_decode
  import degrade_mode_pkg::*;
(
  input  logic [NTASK-1:0] rec_i,
  input  logic             alt_b_i,
  output mode_e            mode_o
);
  always_comb begin
    unique case (rec_i)
      3'b000:  mode_o = MODE_NOM;
      3'b001:  mode_o = MODE_C;
      3'b010:  mode_o = alt_b_i ? MODE_B : MODE_A;
      3'b100:  mode_o = MODE_A;
      3'b110:  mode_o = MODE_A;
      3'b011:  mode_o = MODE_D;
      3'b101:  mode_o = MODE_D;
      default: mode_o = MODE_SURV;
    endcase
  end
endmodule

// File: rtl/dm_apply.sv
module dm_apply
  import degrade_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTASK-1:0] rec_i,
  input  logic             upper_i,
  input  mode_e            mode_i,
  output logic             sync_o,
  output mode_e            mode_o,
  output logic [NTASK-1:0] quar_o,
  output logic             upper_o
);
  logic             sync_q;
  mode_e            tgt_mode_q, app_mode_q;
  logic [NTASK-1:0] tgt_rec_q, app_rec_q;
  logic             tgt_up_q, app_up_q;
  logic             pending;

  assign pending = (rec_i != app_rec_q) || (upper_i != app_up_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= 1'b0;
      tgt_mode_q <= MODE_NOM;
      tgt_rec_q  <= '0;
      tgt_up_q   <= 1'b0;
      app_mode_q <= MODE_NOM;
      app_rec_q  <= '0;
      app_up_q   <= 1'b0;
    end else if (sync_q) begin
      sync_q     <= 1'b0;
      app_mode_q <= tgt_mode_q;
      app_rec_q  <= tgt_rec_q;
      app_up_q   <= tgt_up_q;
    end else if (pending) begin
      sync_q     <= 1'b1;
      tgt_mode_q <= mode_i;
      tgt_rec_q  <= rec_i;
      tgt_up_q   <= upper_i;
    end
  end

  assign sync_o  = sync_q;
  assign mode_o  = app_mode_q;
  assign quar_o  = app_rec_q;
  assign upper_o = app_up_q;
endmodule

// File: rtl/degrade_mode_ctrl.sv
module degrade_mode_ctrl
  import degrade_mode_pkg::*;
#(
  parameter int TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             viol_valid_i,
  input  logic [TID_W-1:0] viol_tid_i,
  input  logic             viol_upper_i,
  input  logic             restore_valid_i,
  input  logic [TID_W-1:0] restore_tid_i,
  input  logic             alt_b_i,
  output logic [2:0]       mode_o,
  output logic [2:0]       quar_o,
  output logic [3:0]       timer_set_o,
  output logic             sync_o
);
  logic [NTASK-1:0] rec;
  logic             rec_upper, app_upper;
  mode_e            dec_mode, app_mode;

  dm_record #(.TID_W(TID_W)) u_record (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .viol_valid_i (viol_valid_i),
    .viol_tid_i   (viol_tid_i),
    .viol_upper_i (viol_upper_i),
    .rest_valid_i (restore_valid_i),
    .rest_tid_i   (restore_tid_i),
    .rec_o        (rec),
    .upper_o      (rec_upper)
  );

  dm_decode u_decode (
    .rec_i   (rec),
    .alt_b_i (alt_b_i),
    .mode_o  (dec_mode)
  );

  dm_apply u_apply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rec_i   (rec),
    .upper_i (rec_upper),
    .mode_i  (dec_mode),
    .sync_o  (sync_o),
    .mode_o  (app_mode),
    .quar_o  (quar_o),
    .upper_o (app_upper)
  );

  assign mode_o      = app_mode;
  assign timer_set_o = {app_mode, app_upper};
endmodule

// File: rtl/degrade_mode_ctrl_chk.sv
module degrade_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restore_valid_i,
  input logic       sync_o,
  input logic [2:0] mode_o,
  input logic [2:0] quar_o,
  input logic [2:0] rec
);
  AST_SYNC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o); // R10
  AST_UPDATE_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mode_o, quar_o}) |-> $past(sync_o)); // R10
  AST_REC_CLEAR_BY_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(rec) & ~rec)) |-> $past(restore_valid_i)); // R6
  AST_SURV_ALL_QUAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |-> (quar_o == 3'b111)); // R5
  AST_NOM_NONE_QUAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0) |-> (quar_o == 3'b000)); // R9
  AST_C_SEQ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> (quar_o == 3'b001)); // R2
  AST_D_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (quar_o[0] && $countones(quar_o) == 2)); // R4
endmodule

bind degrade_mode_ctrl degrade_mode_ctrl_chk u_chk (.*);

// File: tb/degrade_mode_ctrl_bench.sv
module degrade_mode_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       viol_valid_i = 1'b0;
  logic [1:0] viol_tid_i = '0;
  logic       viol_upper_i = 1'b0;
  logic       restore_valid_i = 1'b0;
  logic [1:0] restore_tid_i = '0;
  logic       alt_b_i = 1'b0;
  logic [2:0] mode_o, quar_o;
  logic [3:0] timer_set_o;
  logic       sync_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  degrade_mode_ctrl u_degrade_mode_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk_i);
    rst_ni = 1'b0; alt_b_i = alt;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 mode", mode_o, 0);
    chk("R1 quar", quar_o, 0);
    chk("R1 timer", timer_set_o, 0);
    chk("R1 sync", sync_o, 0);
  endtask

  // rst: 1 restore event, 0 violation; chg: record change expected
  task automatic ev(input string req, input bit rst, input logic [1:0] id, input bit up,
                    input bit chg, input int em, input int eq, input int eu);
    @(negedge clk_i);
    if (rst) begin restore_valid_i = 1'b1; restore_tid_i = id; end
    else begin viol_valid_i = 1'b1; viol_tid_i = id; viol_upper_i = up; end
    @(negedge clk_i);
    viol_valid_i = 1'b0; restore_valid_i = 1'b0;
    chk({req, " R10 no early sync"}, sync_o, 0);
    @(negedge clk_i);
    chk({req, " R10 sync"}, sync_o, int'(chg));
    @(negedge clk_i);
    chk({req, " R10 sync drop"}, sync_o, 0);
    chk({req, " mode"}, mode_o, em);
    chk({req, " R7 quar"}, quar_o, eq);
    chk({req, " R8 timer"}, timer_set_o, em * 2 + eu);
  endtask

  task automatic t_seq_only;
    do_reset(0);
    ev("R2 seq->C", 0, 0, 1, 1, 3, 3'b001, 1);
    ev("R6 repeat seq", 0, 0, 0, 0, 3, 3'b001, 1);
    ev("R6 code3", 0, 3, 0, 0, 3, 3'b001, 1);
    ev("R9 restore est unquar", 1, 1, 0, 0, 3, 3'b001, 1);
  endtask

  task automatic t_rcv_est;
    do_reset(0);
    ev("R3 rcv->A", 0, 2, 0, 1, 1, 3'b100, 0);
    ev("R3 est+rcv->A", 0, 1, 1, 1, 1, 3'b110, 1);
    ev("R4 seq->D? no all", 0, 0, 0, 1, 5, 3'b111, 0);
    ev("R9 restore rcv", 1, 2, 0, 1, 4, 3'b011, 0);
  endtask

  task automatic t_alt_b;
    do_reset(1);
    ev("R3 est->B", 0, 1, 0, 1, 2, 3'b010, 0);
    ev("R4 est+seq->D", 0, 0, 1, 1, 4, 3'b011, 1);
    ev("R5 all->survival", 0, 2, 1, 1, 5, 3'b111, 1);
  endtask

  task automatic t_est_a;
    do_reset(0);
    ev("R3 est->A", 0, 1, 1, 1, 1, 3'b010, 1);
  endtask

  task automatic t_restore;
    do_reset(0);
    ev("R3 rcv->A", 0, 2, 1, 1, 1, 3'b100, 1);
    ev("R4 rcv+seq->D", 0, 0, 0, 1, 4, 3'b101, 0);
    ev("R9 restore seq", 1, 0, 0, 1, 1, 3'b100, 0);
    ev("R9 restore rcv->nominal", 1, 2, 0, 1, 0, 3'b000, 0);
    ev("R9 restore empty", 1, 2, 0, 0, 0, 3'b000, 0);
  endtask

  initial begin
    t_seq_only;
    t_rcv_est;
    t_alt_b;
    t_est_a;
    t_restore;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule